// File: doc/BRIEF.md
# Warp Lane Mask Barrier

This block holds the lanes of one warp at a sync point until a group of them, chosen by a bit mask, has assembled. Each lane has its own arrival slot. A slot presents a valid strobe, its lane ID and a participation mask, where bit i names lane i. The first legal arrival opens an episode and fixes its mask. Later arrivals join that episode only if they present exactly the same mask. When every lane named in the mask has arrived, all of them get a release pulse in the same cycle and the episode closes.

Arrivals that break the protocol are not counted, and each one raises a one-cycle error flag. These are: a mask that leaves out the arriving lane's own bit, a lane ID that does not match its slot, a mask that differs from the open episode's mask, and a second arrival by a lane that is already waiting. The warp width is a parameter, 32 by default.

Top module: `warp_lane_barrier`

## Requirements
- R1: After reset, `lane_go` and `proto_err` are all zero and no episode is open. The first legal arrival afterwards opens a fresh episode.
- R2: When every lane set in mask M arrives in the same cycle with mask M, `lane_go` equals M in the next cycle and `proto_err` stays 0.
- R3: When the members of M arrive over several cycles, `lane_go` stays zero until the last member has arrived. In the cycle after that, `lane_go` equals M.
- R4: A mask that names only the arriving lane releases that lane in the cycle after its arrival.
- R5: An arrival from slot k whose mask has bit k clear raises `proto_err` in the next cycle. It is not counted and does not open an episode.
- R6: While an episode is open, an arrival whose mask differs from the episode's mask raises `proto_err` in the next cycle and is ignored. That lane is not released with the episode.
- R7: A lane that arrives again while it is already waiting raises `proto_err` in the next cycle. The episode continues unchanged.
- R8: An arrival from slot k whose lane ID is not k raises `proto_err` in the next cycle and is ignored.
- R9: When no episode is open and legal arrivals in one cycle carry different masks, the lowest-numbered slot's mask opens the episode. The other arrivals are flagged as in R6.
- R10: Arrival tracking clears on the same clock edge that produces the release pulse. An arrival made during the release cycle counts toward a new episode.
- R11: `proto_err` is a single-cycle pulse and returns to 0 after a cycle with no violation. `lane_go` is also a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_vld | input | LANES | Per-slot arrival strobe |
| arr_mask | input | LANES*LANES | Per-slot participation mask; slot k occupies bits [k*LANES +: LANES] |
| arr_lane | input | LANES*IDW | Per-slot lane ID; slot k occupies bits [k*IDW +: IDW] |
| lane_go | output | LANES | Registered per-lane release pulse |
| proto_err | output | 1 | Registered one-cycle protocol error flag |

## Verification
The hardest situations to reach are the ones where two things happen at the same clock edge. One is an arrival in the very cycle a release pulse is visible. The other is several arrivals with conflicting masks while no episode is open. The bench reaches both with back-to-back single-cycle stimulus steps on a four-lane build. Before those, it sweeps all fifteen nonzero masks, once with every member arriving at once and once with members arriving one per cycle. After each error case, a follow-up arrival whose release can be predicted shows whether the rejected arrival left any trace in the tracking state.

// File: rtl/wlb_pkg.sv
// Package: shared types for the warp lane mask barrier.
// Assumes nothing beyond a standard elaborator.
package wlb_pkg;

    localparam int unsigned WLB_DEFAULT_LANES = 32;

    // Outcome of screening one slot's arrival in one cycle.
    typedef enum logic [1:0] {
        LV_IDLE   = 2'd0,
        LV_ACCEPT = 2'd1,
        LV_REJECT = 2'd2
    } lane_verdict_t;

endpackage

// File: rtl/wlb_lane_check.sv
// Module: screens the arrival of one slot against the protocol.
// Assumes the reference mask is already settled for the cycle. The
// candidate output does not depend on the reference mask, which avoids
// a combinational loop through the reference picker.
module wlb_lane_check
    import wlb_pkg::*;
#(
    parameter int unsigned LANES = WLB_DEFAULT_LANES,
    parameter int unsigned IDW   = (LANES > 1) ? $clog2(LANES) : 1,
    parameter int unsigned LANE  = 0
) (
    input  logic             vld,
    input  logic [LANES-1:0] mask,
    input  logic [IDW-1:0]   lane_id,
    input  logic [LANES-1:0] ref_mask,
    input  logic             waiting,
    output logic             cand,
    output lane_verdict_t    verdict
);

    localparam logic [IDW-1:0] MY_ID = IDW'(LANE);

    // Candidacy: the slot's ID is its own, and its own bit is in the mask.
    always_comb begin
        cand = vld && (lane_id == MY_ID) && mask[LANE];
    end

    // Verdict: accept only a candidate that matches the reference and is not already waiting.
    always_comb begin
        if (!vld)
            verdict = LV_IDLE;
        else if (cand && (mask == ref_mask) && !waiting)
            verdict = LV_ACCEPT;
        else
            verdict = LV_REJECT;
    end

endmodule

// File: rtl/wlb_ref_pick.sv
// Module: picks the mask that would open a new episode in this cycle.
// This is the mask of the lowest-numbered candidate slot. Assumes the
// masks are packed per slot, LANES bits each.
module wlb_ref_pick #(
    parameter int unsigned LANES = 32
) (
    input  logic [LANES-1:0]       cand,
    input  logic [LANES*LANES-1:0] masks,
    output logic [LANES-1:0]       first_mask
);

    // Priority scan: walking downward lets the lowest index win.
    always_comb begin
        first_mask = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (cand[k])
                first_mask = masks[k*LANES +: LANES];
        end
    end

endmodule

// File: rtl/wlb_episode.sv
// Module: holds the episode state (open flag, latched mask, waiting lanes).
// Drives the registered release and error outputs. Assumes that every
// accepted lane is a member of the reference mask.
module wlb_episode #(
    parameter int unsigned LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] first_mask,
    input  logic [LANES-1:0] acc,
    input  logic             any_bad,
    output logic [LANES-1:0] ref_mask,
    output logic [LANES-1:0] wait_q,
    output logic             open_q,
    output logic [LANES-1:0] ep_mask_q,
    output logic [LANES-1:0] go_q,
    output logic             err_q
);

    logic [LANES-1:0] wait_nx;
    logic             done;

    // Reference: the latched mask when an episode is open, otherwise the picked mask.
    always_comb begin
        ref_mask = open_q ? ep_mask_q : first_mask;
    end

    // Completion: the union of waiting and accepted lanes covers the reference.
    always_comb begin
        wait_nx = wait_q | acc;
        done    = (open_q || (|acc)) && ((wait_nx & ref_mask) == ref_mask);
    end

    // State update: release and clear on completion, otherwise open or extend the episode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q    <= 1'b0;
            ep_mask_q <= '0;
            wait_q    <= '0;
            go_q      <= '0;
            err_q     <= 1'b0;
        end else begin
            err_q <= any_bad;
            if (done) begin
                go_q      <= ref_mask;
                wait_q    <= '0;
                open_q    <= 1'b0;
                ep_mask_q <= '0;
            end else begin
                go_q <= '0;
                if (|acc) begin
                    open_q    <= 1'b1;
                    ep_mask_q <= ref_mask;
                    wait_q    <= wait_nx;
                end
            end
        end
    end

endmodule

// File: rtl/warp_lane_barrier.sv
// Module: top of the warp lane mask barrier.
// It screens the per-slot arrivals, picks the opening mask and tracks one
// episode at a time. Assumes LANES >= 2. Slot k carries lane k.
module warp_lane_barrier
    import wlb_pkg::*;
#(
    parameter int unsigned LANES = WLB_DEFAULT_LANES,
    localparam int unsigned IDW  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       arr_vld,
    input  logic [LANES*LANES-1:0] arr_mask,
    input  logic [LANES*IDW-1:0]   arr_lane,
    output logic [LANES-1:0]       lane_go,
    output logic                   proto_err
);

    logic [LANES-1:0] cand;
    logic [LANES-1:0] acc;
    logic [LANES-1:0] bad;
    logic [LANES-1:0] first_mask;
    logic [LANES-1:0] ref_mask;
    logic [LANES-1:0] wait_q;
    logic [LANES-1:0] ep_mask_q;
    logic             open_q;

    // One screening instance per slot.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_verdict_t verdict;

        wlb_lane_check #(
            .LANES (LANES),
            .IDW   (IDW),
            .LANE  (k)
        ) u_chk (
            .vld      (arr_vld[k]),
            .mask     (arr_mask[k*LANES +: LANES]),
            .lane_id  (arr_lane[k*IDW +: IDW]),
            .ref_mask (ref_mask),
            .waiting  (wait_q[k]),
            .cand     (cand[k]),
            .verdict  (verdict)
        );

        assign acc[k] = (verdict == LV_ACCEPT);
        assign bad[k] = (verdict == LV_REJECT);
    end

    wlb_ref_pick #(
        .LANES (LANES)
    ) u_pick (
        .cand       (cand),
        .masks      (arr_mask),
        .first_mask (first_mask)
    );

    wlb_episode #(
        .LANES (LANES)
    ) u_ep (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_mask (first_mask),
        .acc        (acc),
        .any_bad    (|bad),
        .ref_mask   (ref_mask),
        .wait_q     (wait_q),
        .open_q     (open_q),
        .ep_mask_q  (ep_mask_q),
        .go_q       (lane_go),
        .err_q      (proto_err)
    );

endmodule

// Module: protocol checker attached to every warp_lane_barrier instance.
// Assumes a synchronous active-low reset.
module warp_lane_barrier_chk #(
    parameter int unsigned LANES = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] arr_vld,
    input logic [LANES-1:0] go,
    input logic             err,
    input logic [LANES-1:0] wait_q,
    input logic             open_q,
    input logic [LANES-1:0] ep_mask_q
);

    // R2 / R3: a release only follows a cycle that had an arrival.
    a_r3_go_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        (|go) |-> $past(|arr_vld));

    // R11: the error flag only follows a cycle that had an arrival.
    a_r11_err_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(|arr_vld));

    // R3: every lane that was waiting before the completing edge is released.
    a_r3_release_covers_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (|go) |-> (($past(wait_q) & ~go) == '0));

    // R5: a released lane was either waiting or arriving at the previous edge.
    a_r5_no_phantom_release: assert property (@(posedge clk) disable iff (!rst_n)
        (go & ~($past(wait_q) | $past(arr_vld))) == '0);

    // R6: the latched mask does not change while the episode stays open.
    a_r6_mask_stable_open: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && $past(open_q)) |-> $stable(ep_mask_q));

    // R10: release clears the tracking on the same edge.
    a_r10_clear_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        (|go) |-> (!open_q && (wait_q == '0)));

endmodule

bind warp_lane_barrier warp_lane_barrier_chk #(.LANES(LANES)) u_wlb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr_vld   (arr_vld),
    .go        (lane_go),
    .err       (proto_err),
    .wait_q    (wait_q),
    .open_q    (open_q),
    .ep_mask_q (ep_mask_q)
);

// File: tb/tb_warp_lane_barrier.sv
`timescale 1ns/1ps
module tb_warp_lane_barrier;

    localparam int unsigned LANES = 4;
    localparam int unsigned IDW   = 2;
    localparam logic [7:0]  IDS   = 8'he4; // slot k carries ID k

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [LANES-1:0]       arr_vld = '0;
    logic [LANES*LANES-1:0] arr_mask = '0;
    logic [LANES*IDW-1:0]   arr_lane = '0;
    logic [LANES-1:0]       lane_go;
    logic                   proto_err;

    logic [LANES-1:0] got_go;
    logic             got_err;
    int               n_chk = 0;
    int               n_bad = 0;
    bit               done_flag = 1'b0;

    always #4 clk = ~clk;

    warp_lane_barrier #(.LANES(LANES)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .arr_vld   (arr_vld),
        .arr_mask  (arr_mask),
        .arr_lane  (arr_lane),
        .lane_go   (lane_go),
        .proto_err (proto_err)
    );

    // Drives one cycle of stimulus, samples the outputs after the edge, then clears the inputs.
    task automatic step(input logic [3:0] v, input logic [15:0] m, input logic [7:0] id);
        @(negedge clk);
        arr_vld  = v;
        arr_mask = m;
        arr_lane = id;
        @(posedge clk);
        #2;
        got_go   = lane_go;
        got_err  = proto_err;
        arr_vld  = '0;
        arr_mask = '0;
        arr_lane = '0;
    endtask

    task automatic check(input string req, input logic [3:0] go_exp, input logic err_exp);
        n_chk++;
        if (got_go !== go_exp || got_err !== err_exp) begin
            n_bad++;
            $display("FAIL %s: go=%b err=%b expected go=%b err=%b",
                     req, got_go, got_err, go_exp, err_exp);
        end
    endtask

    function automatic logic [15:0] one(input int k, input logic [3:0] m);
        return 16'(m) << (4 * k);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #2;
        got_go = lane_go;
        got_err = proto_err;
        check("R1 reset outputs", 4'b0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: no episode open after reset, so a lone member releases at once.
        step(4'b1000, one(3, 4'b1000), IDS);
        check("R1 fresh episode", 4'b1000, 1'b0);
        step(4'b0000, 16'h0, IDS);
        check("R11 go pulse ends", 4'b0000, 1'b0);

        // R2: all members arrive together, for every nonzero mask.
        for (int m = 1; m < 16; m++) begin
            step(4'(m), {4{4'(m)}}, IDS);
            check("R2 simultaneous", 4'(m), 1'b0);
            step(4'b0000, 16'h0, IDS);
            check("R11 idle after release", 4'b0000, 1'b0);
        end

        // R3 / R4: members arrive one per cycle in ascending order.
        for (int m = 1; m < 16; m++) begin
            for (int k = 0; k < 4; k++) begin
                if (m[k]) begin
                    step(4'(1 << k), {4{4'(m)}}, IDS);
                    if ((m >> (k + 1)) == 0)
                        check("R3 R4 last member releases", 4'(m), 1'b0);
                    else
                        check("R3 held until last", 4'b0000, 1'b0);
                end
            end
        end

        // R10: an arrival in the release cycle starts a new episode.
        step(4'b0011, {4{4'b0011}}, IDS);
        check("R10 release", 4'b0011, 1'b0);
        step(4'b0100, one(2, 4'b0100), IDS);
        check("R10 arrival during release", 4'b0100, 1'b0);

        // R5: own bit clear is flagged, not counted, opens nothing.
        step(4'b0001, one(0, 4'b0010), IDS);
        check("R5 own bit clear", 4'b0000, 1'b1);
        step(4'b0010, one(1, 4'b0010), IDS);
        check("R5 rejected lane not counted", 4'b0010, 1'b0);

        // R6: mask mismatch against an open episode.
        step(4'b0001, one(0, 4'b0011), IDS);
        check("R6 open", 4'b0000, 1'b0);
        step(4'b0100, one(2, 4'b0110), IDS);
        check("R6 mismatch flagged", 4'b0000, 1'b1);
        step(4'b0010, one(1, 4'b0011), IDS);
        check("R6 release excludes mismatched", 4'b0011, 1'b0);

        // R7: repeated arrival while waiting.
        step(4'b0001, one(0, 4'b0111), IDS);
        check("R7 open", 4'b0000, 1'b0);
        step(4'b0001, one(0, 4'b0111), IDS);
        check("R7 repeat flagged", 4'b0000, 1'b1);
        step(4'b0010, one(1, 4'b0111), IDS);
        check("R7 episode continues", 4'b0000, 1'b0);
        step(4'b0100, one(2, 4'b0111), IDS);
        check("R7 release", 4'b0111, 1'b0);

        // R8: slot 1 presents lane ID 2.
        step(4'b0010, one(1, 4'b0110), 8'he8);
        check("R8 wrong id flagged", 4'b0000, 1'b1);
        step(4'b1000, one(3, 4'b1000), IDS);
        check("R8 nothing opened", 4'b1000, 1'b0);

        // R9: conflicting masks in one cycle, lowest slot wins.
        step(4'b0011, one(0, 4'b0101) | one(1, 4'b0011), IDS);
        check("R9 conflict flagged", 4'b0000, 1'b1);
        step(4'b0100, one(2, 4'b0101), IDS);
        check("R9 lowest slot mask used", 4'b0101, 1'b0);
        step(4'b0000, 16'h0, IDS);
        check("R11 err pulse ends", 4'b0000, 1'b0);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: go=%b err=%b expected run to end", lane_go, proto_err);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule